// File: doc/BRIEF.md
# Vector Compare-Immediate Sequencer with Fail-First Truncation

This block steps a signed compare-immediate across a vector of integer registers, one element per clock, and writes a three-bit condition field for each element into a condition array. A start pulse supplies the source base register, the destination base field, the immediate, a requested vector length and the mode bits. Either side can be marked as vectorised, so that its offset steps with the element index, or as scalar, so that it stays pinned to its base. This lets the scalar-scalar, scalar-vector and vector-vector forms all run on one datapath.

With fail-first enabled, a chosen bit of each freshly produced condition field, optionally inverted, acts as a pass/fail test. The first failing element ends the loop. In inclusive mode the failing element is committed and counted. In exclusive mode it is dropped, which can leave a length of zero. The block reports the resulting length with a one-cycle done flag. The integer registers are loaded through a write port. The condition array can be read back through a read port, and every commit is also visible on the write strobe outputs.

Top module: `vcmp_failfirst`

## Requirements
- R1: While reset is held and after it is released: busy, done and cf_we are 0, and every condition array entry reads 0.
- R2: An accepted start with a nonzero length puts element i on the commit outputs in the i-th cycle after the start edge, one element per cycle. The written field holds bit 2 = (source < imm), bit 1 = (source > imm) and bit 0 = (source == imm), all compared signed.
- R3: The field address is (ba + i) mod NCF when dst_vec is 1, and ba for every element when dst_vec is 0.
- R4: The source register is (ra + i) mod NREG when src_vec is 1, and ra for every element when src_vec is 0.
- R5: An element fails when the selected field bit, XORed with tinv, is 1. tsel 0 selects bit 0, 1 selects bit 1, 2 selects bit 2, and 3 selects a constant 0.
- R6: With ff_en=1 and ff_excl=0, the first failing element i is committed, nothing after it is committed, and vl_out = i+1.
- R7: With ff_en=1 and ff_excl=1, the first failing element i is not committed, nothing after it is committed, and vl_out = i. This includes 0 when i = 0.
- R8: With ff_en=0, all vl_in elements are committed whatever the test gives, and vl_out = vl_in.
- R9: A start with vl_in = 0 raises done in the first cycle after the start edge, with no commits and vl_out = 0.
- R10: done lasts exactly one cycle and comes one cycle after the last examined element. vl_out is valid while done is high. busy is high from the start edge through the done cycle, and a start pulse while busy is ignored.
- R11: cf_rdata returns the field most recently committed at cf_raddr. Entries that an operation does not write keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rf_we | input | 1 | Integer register write enable |
| rf_waddr | input | $clog2(NREG) | Integer register write address |
| rf_wdata | input | XLEN | Integer register write data |
| start | input | 1 | Start pulse, taken when not busy |
| ra | input | $clog2(NREG) | Source base register |
| ba | input | $clog2(NCF) | Destination base field |
| simm | input | XLEN | Signed immediate |
| vl_in | input | $clog2(MAXVL+1) | Requested vector length |
| src_vec | input | 1 | Source is vectorised |
| dst_vec | input | 1 | Destination is vectorised |
| ff_en | input | 1 | Fail-first enable |
| ff_excl | input | 1 | Exclusive truncation |
| tsel | input | 2 | Field bit tested |
| tinv | input | 1 | Invert the test |
| busy | output | 1 | Operation in progress |
| cf_we | output | 1 | Field commit strobe |
| cf_addr | output | $clog2(NCF) | Address of committed field |
| cf_data | output | 3 | Committed field value |
| cf_raddr | input | $clog2(NCF) | Condition array read address |
| cf_rdata | output | 3 | Condition array read data |
| done | output | 1 | Operation finished, one cycle |
| vl_out | output | $clog2(MAXVL+1) | Resulting vector length |

## Verification
The bench aims for a failure at element zero in exclusive mode. A design that commits before it tests would leave one stray field there, and a design that miscounts would report a length of one instead of zero. It also hits a failure in the middle of a vector. Both inclusive and exclusive truncation are used there, so an off-by-one in the reported length or a commit of the dropped element shows up on the strobe. Register and field indices that wrap past the top of their files are covered too, along with scalar destinations that must keep overwriting one field, a zero length that must finish at once, and a start pulse mid-run that a careless sequencer would restart on.

// File: rtl/ffcmp_pkg.sv
`timescale 1ns/1ps
package ffcmp_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;

  localparam int FLD_W  = 3;
  localparam int FLD_LT = 2;
  localparam int FLD_GT = 1;
  localparam int FLD_EQ = 0;

  typedef logic [FLD_W-1:0] cfield_t;
endpackage

// File: rtl/ffcmp_rstsync.sv
`timescale 1ns/1ps
module ffcmp_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/ffcmp_intrf.sv
`timescale 1ns/1ps
module ffcmp_intrf #(
  parameter int XLEN = 16,
  parameter int NREG = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   raddr,
  output logic [XLEN-1:0] rdata
);
  logic [XLEN-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic en;
    assign en = we && (waddr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs_q[g] <= '0;
      else if (en) regs_q[g] <= wdata;
    end
  end

  assign rdata = regs_q[raddr];
endmodule

// File: rtl/ffcmp_cfarr.sv
`timescale 1ns/1ps
module ffcmp_cfarr
  import ffcmp_pkg::*;
#(
  parameter int NCF = 16,
  localparam int AW = $clog2(NCF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  cfield_t       wdata,
  input  logic [AW-1:0] raddr,
  output cfield_t       rdata
);
  cfield_t fld_q [NCF];

  for (genvar g = 0; g < NCF; g++) begin : g_fld
    logic en;
    assign en = we && (waddr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  fld_q[g] <= '0;
      else if (en) fld_q[g] <= wdata;
    end
  end

  assign rdata = fld_q[raddr];
endmodule

// File: rtl/ffcmp_cmp.sv
`timescale 1ns/1ps
module ffcmp_cmp
  import ffcmp_pkg::*;
#(
  parameter int XLEN = 16
) (
  input  logic [XLEN-1:0] src,
  input  logic [XLEN-1:0] imm,
  input  logic [1:0]      tsel,
  input  logic            tinv,
  output cfield_t         field,
  output logic            fail
);
  logic tbit;

  always_comb begin
    field         = '0;
    field[FLD_LT] = $signed(src) <  $signed(imm);
    field[FLD_GT] = $signed(src) >  $signed(imm);
    field[FLD_EQ] = src == imm;
  end

  always_comb begin
    unique case (tsel)
      2'd0:    tbit = field[0];
      2'd1:    tbit = field[1];
      2'd2:    tbit = field[2];
      default: tbit = 1'b0;
    endcase
  end

  assign fail = tbit ^ tinv;
endmodule

// File: rtl/vcmp_failfirst.sv
`timescale 1ns/1ps
module vcmp_failfirst
  import ffcmp_pkg::*;
#(
  parameter int XLEN  = 16,
  parameter int NREG  = 16,
  parameter int NCF   = 16,
  parameter int MAXVL = 16,
  localparam int RAW  = $clog2(NREG),
  localparam int CAW  = $clog2(NCF),
  localparam int VLW  = $clog2(MAXVL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rf_we,
  input  logic [RAW-1:0]  rf_waddr,
  input  logic [XLEN-1:0] rf_wdata,
  input  logic            start,
  input  logic [RAW-1:0]  ra,
  input  logic [CAW-1:0]  ba,
  input  logic [XLEN-1:0] simm,
  input  logic [VLW-1:0]  vl_in,
  input  logic            src_vec,
  input  logic            dst_vec,
  input  logic            ff_en,
  input  logic            ff_excl,
  input  logic [1:0]      tsel,
  input  logic            tinv,
  output logic            busy,
  output logic            cf_we,
  output logic [CAW-1:0]  cf_addr,
  output logic [2:0]      cf_data,
  input  logic [CAW-1:0]  cf_raddr,
  output logic [2:0]      cf_rdata,
  output logic            done,
  output logic [VLW-1:0]  vl_out
);
  logic rst_sn;

  ffcmp_rstsync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sn)
  );

  // captured operation
  logic [RAW-1:0]  op_ra_q;
  logic [CAW-1:0]  op_ba_q;
  logic [XLEN-1:0] op_imm_q;
  logic [VLW-1:0]  op_vl_q;
  logic            op_sv_q, op_dv_q, op_ff_q, op_ex_q, op_ti_q;
  logic [1:0]      op_ts_q;

  // sequencing state
  seq_state_e     st_q, st_d;
  logic [VLW-1:0] idx_q, idx_d;
  logic [RAW-1:0] soff_q, soff_d;
  logic [CAW-1:0] doff_q, doff_d;
  logic [VLW-1:0] res_q, res_d;

  logic            accept;
  logic [RAW-1:0]  src_addr;
  logic [XLEN-1:0] src_val;
  cfield_t         fld;
  logic            elem_fail;
  logic            stop_now;
  logic            last_elem;
  logic            commit;

  assign accept   = start && (st_q == SEQ_IDLE);
  assign src_addr = op_ra_q + soff_q;

  ffcmp_intrf #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk   (clk),
    .rst_n (rst_sn),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .raddr (src_addr),
    .rdata (src_val)
  );

  ffcmp_cmp #(.XLEN(XLEN)) u_cmp (
    .src   (src_val),
    .imm   (op_imm_q),
    .tsel  (op_ts_q),
    .tinv  (op_ti_q),
    .field (fld),
    .fail  (elem_fail)
  );

  // capture registers, enabled on accept
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      op_ra_q  <= '0;
      op_ba_q  <= '0;
      op_imm_q <= '0;
      op_vl_q  <= '0;
      op_sv_q  <= 1'b0;
      op_dv_q  <= 1'b0;
      op_ff_q  <= 1'b0;
      op_ex_q  <= 1'b0;
      op_ts_q  <= '0;
      op_ti_q  <= 1'b0;
    end else if (accept) begin
      op_ra_q  <= ra;
      op_ba_q  <= ba;
      op_imm_q <= simm;
      op_vl_q  <= vl_in;
      op_sv_q  <= src_vec;
      op_dv_q  <= dst_vec;
      op_ff_q  <= ff_en;
      op_ex_q  <= ff_excl;
      op_ts_q  <= tsel;
      op_ti_q  <= tinv;
    end
  end

  assign last_elem = (idx_q == op_vl_q - VLW'(1));
  assign stop_now  = op_ff_q && elem_fail;

  // next state
  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    soff_d = soff_q;
    doff_d = doff_q;
    res_d  = res_q;
    commit = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        if (start) begin
          idx_d  = '0;
          soff_d = '0;
          doff_d = '0;
          if (vl_in == '0) begin
            res_d = '0;
            st_d  = SEQ_DONE;
          end else begin
            st_d  = SEQ_RUN;
          end
        end
      end
      SEQ_RUN: begin
        commit = !(stop_now && op_ex_q);
        if (stop_now) begin
          res_d = op_ex_q ? idx_q : idx_q + VLW'(1);
          st_d  = SEQ_DONE;
        end else if (last_elem) begin
          res_d = op_vl_q;
          st_d  = SEQ_DONE;
        end else begin
          idx_d  = idx_q + VLW'(1);
          soff_d = soff_q + RAW'(op_sv_q);
          doff_d = doff_q + CAW'(op_dv_q);
        end
      end
      SEQ_DONE: st_d = SEQ_IDLE;
      default:  st_d = SEQ_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= SEQ_IDLE;
      idx_q  <= '0;
      soff_q <= '0;
      doff_q <= '0;
      res_q  <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      soff_q <= soff_d;
      doff_q <= doff_d;
      res_q  <= res_d;
    end
  end

  ffcmp_cfarr #(.NCF(NCF)) u_cf (
    .clk   (clk),
    .rst_n (rst_sn),
    .we    (commit),
    .waddr (cf_addr),
    .wdata (fld),
    .raddr (cf_raddr),
    .rdata (cf_rdata)
  );

  assign cf_we   = commit;
  assign cf_addr = op_ba_q + doff_q;
  assign cf_data = fld;
  assign busy    = (st_q != SEQ_IDLE);
  assign done    = (st_q == SEQ_DONE);
  assign vl_out  = res_q;
endmodule

// File: rtl/ffcmp_chk.sv
`timescale 1ns/1ps
module ffcmp_chk #(
  parameter int NCF   = 16,
  parameter int MAXVL = 16,
  localparam int CAW  = $clog2(NCF),
  localparam int VLW  = $clog2(MAXVL + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic [VLW-1:0] vl_in,
  input logic           ff_en,
  input logic           dst_vec,
  input logic [CAW-1:0] ba,
  input logic           cf_we,
  input logic [CAW-1:0] cf_addr,
  input logic           done,
  input logic [VLW-1:0] vl_out
);
  logic           take;
  logic [VLW-1:0] k_vl, k_wr;
  logic           k_ff, k_dv;
  logic [CAW-1:0] k_ba;

  assign take = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_vl <= '0;
      k_wr <= '0;
      k_ff <= 1'b0;
      k_dv <= 1'b0;
      k_ba <= '0;
    end else if (take) begin
      k_vl <= vl_in;
      k_wr <= '0;
      k_ff <= ff_en;
      k_dv <= dst_vec;
      k_ba <= ba;
    end else if (cf_we) begin
      k_wr <= k_wr + VLW'(1);
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_commit_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cf_we |-> (busy && !done));

  assert_zero_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vl_in == '0) |=> (done && vl_out == '0));

  assert_commit_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (k_wr == vl_out));

  assert_trunc_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (vl_out <= k_vl));

  assert_full_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !k_ff) |-> (vl_out == k_vl));

  assert_scalar_dst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cf_we && !k_dv) |-> (cf_addr == k_ba));
endmodule

bind vcmp_failfirst ffcmp_chk #(.NCF(NCF), .MAXVL(MAXVL)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .vl_in   (vl_in),
  .ff_en   (ff_en),
  .dst_vec (dst_vec),
  .ba      (ba),
  .cf_we   (cf_we),
  .cf_addr (cf_addr),
  .done    (done),
  .vl_out  (vl_out)
);

// File: tb/vcmp_failfirst_bench.sv
`timescale 1ns/1ps
module vcmp_failfirst_bench;
  localparam int NR = 16;
  localparam int NC = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rf_we;
  logic [3:0]  rf_waddr;
  logic [15:0] rf_wdata;
  logic        start;
  logic [3:0]  ra;
  logic [3:0]  ba;
  logic [15:0] simm;
  logic [4:0]  vl_in;
  logic        src_vec, dst_vec, ff_en, ff_excl, tinv;
  logic [1:0]  tsel;
  logic        busy, cf_we, done;
  logic [3:0]  cf_addr, cf_raddr;
  logic [2:0]  cf_data, cf_rdata;
  logic [4:0]  vl_out;

  int vecs = 0;
  int fails = 0;
  int rf_m [NR];
  int cf_m [NC];

  always #4 clk = ~clk;

  vcmp_failfirst u_vcmp_failfirst (
    .clk(clk), .rst_n(rst_n), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .start(start), .ra(ra), .ba(ba), .simm(simm),
    .vl_in(vl_in), .src_vec(src_vec), .dst_vec(dst_vec), .ff_en(ff_en),
    .ff_excl(ff_excl), .tsel(tsel), .tinv(tinv), .busy(busy),
    .cf_we(cf_we), .cf_addr(cf_addr), .cf_data(cf_data),
    .cf_raddr(cf_raddr), .cf_rdata(cf_rdata), .done(done), .vl_out(vl_out)
  );

  task automatic chk(bit ok, string what, int act, int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog R10 actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  task automatic read_all(string tag);
    for (int a = 0; a < NC; a++) begin
      @(negedge clk);
      cf_raddr = 4'(a);
      #1;
      chk(int'(cf_rdata) == cf_m[a], tag, int'(cf_rdata), cf_m[a]);
    end
  endtask

  // behavioural reference: per-element walk, then compare cycle by cycle
  task automatic run_op(int a_ra, int a_ba, int imm, int vl, bit sv, bit dv,
                        bit ff, bit ex, int ts, bit ti, bit poke, string tag);
    int ea [$];
    int ed [$];
    int k, nw, ev;
    k = vl; nw = vl; ev = vl;
    for (int i = 0; i < vl; i++) begin
      int s, d, v, f, tb;
      bit fl;
      s = sv ? (a_ra + i) % NR : a_ra;
      d = dv ? (a_ba + i) % NC : a_ba;
      v = rf_m[s];
      f = ((v < imm) ? 4 : 0) + ((v > imm) ? 2 : 0) + ((v == imm) ? 1 : 0);
      tb = (ts == 3) ? 0 : ((f >> ts) & 1);
      fl = ff && ((tb ^ int'(ti)) == 1);
      if (fl && ex) begin k = i + 1; nw = i; ev = i; break; end
      ea.push_back(d); ed.push_back(f); cf_m[d] = f;
      if (fl) begin k = i + 1; nw = i + 1; ev = i + 1; break; end
    end
    @(negedge clk);
    ra = 4'(a_ra); ba = 4'(a_ba); simm = 16'(imm); vl_in = 5'(vl);
    src_vec = sv; dst_vec = dv; ff_en = ff; ff_excl = ex;
    tsel = 2'(ts); tinv = ti; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; ; t++) begin
      chk(done == (t == k), {tag, " done timing R10"}, int'(done), int'(t == k));
      chk(busy == 1'b1, {tag, " busy R10"}, int'(busy), 1);
      chk(cf_we == (t < nw), {tag, " commit strobe R2"}, int'(cf_we), int'(t < nw));
      if (t < nw && cf_we) begin
        chk(int'(cf_addr) == ea[t], {tag, " field address R3/R4"}, int'(cf_addr), ea[t]);
        chk(int'(cf_data) == ed[t], {tag, " field value R2/R5"}, int'(cf_data), ed[t]);
      end
      if (t == k) begin
        chk(int'(vl_out) == ev, {tag, " result length R6/R7/R8"}, int'(vl_out), ev);
        start = 1'b0;
        break;
      end
      if (poke && t == 1) begin
        start = 1'b1; vl_in = 5'd2; ra = 4'd9; simm = 16'd0;
      end
      if (poke && t == 2) start = 1'b0;
      @(negedge clk);
    end
    @(negedge clk);
    chk(!done && !busy, {tag, " single done R10"}, int'(done), 0);
  endtask

  initial begin
    rst_n = 1'b0; rf_we = 1'b0; rf_waddr = '0; rf_wdata = '0; start = 1'b0;
    ra = '0; ba = '0; simm = '0; vl_in = '0; src_vec = 1'b0; dst_vec = 1'b0;
    ff_en = 1'b0; ff_excl = 1'b0; tsel = '0; tinv = 1'b0; cf_raddr = '0;
    for (int a = 0; a < NC; a++) cf_m[a] = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !cf_we, "reset outputs R1", int'(busy | done | cf_we), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !cf_we, "post-reset outputs R1", int'(busy | done | cf_we), 0);
    read_all("reset array R1");

    for (int r = 0; r < NR; r++) begin
      @(negedge clk);
      rf_m[r] = r * 7 - 40;
      rf_we = 1'b1; rf_waddr = 4'(r); rf_wdata = 16'(rf_m[r]);
    end
    @(negedge clk);
    rf_we = 1'b0;

    // vector-vector, no fail-first, stray start mid-run (R8, R10)
    run_op(2, 4, 0, 8, 1, 1, 0, 0, 0, 0, 1, "vv plain R8");
    // scalar source, vector destination (R4)
    run_op(7, 0, 9, 5, 0, 1, 0, 0, 0, 0, 0, "sv R4");
    // vector source, scalar destination (R3)
    run_op(3, 12, -5, 6, 1, 0, 0, 0, 0, 0, 0, "vs R3");
    // scalar-scalar with fail-first that never fires (R5, R8)
    run_op(5, 15, 1, 4, 0, 0, 1, 0, 0, 0, 0, "ss ff nofail R5");
    read_all("array after forms R11");
    // inclusive, fail in the middle on GT (R6)
    run_op(6, 0, 20, 8, 1, 1, 1, 0, 1, 0, 0, "incl mid R6");
    // exclusive, same data (R7)
    run_op(6, 8, 20, 8, 1, 1, 1, 1, 1, 0, 0, "excl mid R7");
    // exclusive, fail at element zero: length 0 (R7)
    run_op(0, 3, 0, 5, 1, 1, 1, 1, 2, 0, 0, "excl zero R7");
    // zero requested length (R9)
    run_op(4, 4, 0, 0, 1, 1, 1, 0, 0, 0, 0, "zero vl R9");
    // constant test inverted: always fails, inclusive (R5, R6)
    run_op(1, 10, 0, 7, 1, 1, 1, 0, 3, 1, 0, "const fail R5");
    // inverted GT, exclusive, source wraps (R4, R5, R7)
    run_op(10, 13, 25, 10, 1, 1, 1, 1, 1, 1, 1, "wrap excl R4");
    // full length with both indices wrapping (R2, R3)
    run_op(14, 13, 2, 16, 1, 1, 0, 0, 0, 0, 0, "max wrap R3");
    read_all("array final R11");
    finish_run();
  end
endmodule